// File: doc/BRIEF.md
# Adaptive Bank Page-Policy Sequencer

This block drives one DRAM bank. It takes one read or write request at a time, looks at the bank's row buffer, and issues the precharge, activate and column commands that the access needs. It also keeps the minimum spacing between commands. It records whether the bank is idle or holds an open row, and which row that is. Every request is sorted into one of three kinds:
- a row hit, which needs a column command only;
- a closed-row access, which needs an activate and then a column command;
- a row conflict, which needs a precharge, an activate and a column command.

When an access completes, a page policy decides whether the row stays open or the bank is precharged. The policy can be fixed at open-page or close-page. It can also be adaptive: a small saturating counter goes up on hits and down on conflicts. While the counter is at or above a threshold that software sets, the row is left open. Below that threshold the bank is closed after each access.

Requests come in on a valid/ready port. `req_ready` is high only while the sequencer is idle. A request is taken in the cycle where `req_valid` and `req_ready` are both high. Once `req_ready` has dropped, the source holds off, and it may keep `req_valid` asserted while it waits. The completion side has no back-pressure. Each accepted request returns exactly one single-cycle `done_valid` pulse together with its access kind. Refresh, data movement, arbitration between banks and the physical interface are handled outside this block.

Top module: `dram_page_sequencer`

## Requirements
- R1: A row hit (bank open on the requested row) is reported with `done_kind` = 0. It issues a single column command with no precharge or activate. `done_valid` pulses 1 + tCL cycles after the accept cycle.
- R2: A closed-row access (no row open) is reported with `done_kind` = 1. It issues one activate carrying the row, then the column command. Completion comes 1 + tRCD + tCL cycles after accept.
- R3: A row conflict (a different row open) is reported with `done_kind` = 2. It issues precharge, then activate, then column. Completion comes 1 + tRP + tRCD + tCL cycles after accept.
- R4: An activate comes at least tRP cycles after the preceding precharge. A column command comes at least tRCD cycles after the preceding activate. `done_valid` comes exactly tCL cycles after the column command. A programmed timing value of 0 acts as 1.
- R5: Under open-page policy (`policy_sel` = 0), the row stays open after completion. No precharge follows, and `req_ready` returns in the cycle after `done_valid`.
- R6: Under close-page policy (`policy_sel` = 1), a precharge is issued in the cycle after `done_valid`. `req_ready` returns tRP cycles after that precharge, and the next access finds the bank closed.
- R7: Under adaptive policy (`policy_sel` = 2 or 3), a 4-bit counter starts at 8 after reset. It adds 1 on each accepted hit and subtracts 1 on each accepted conflict, saturating at 15 and 0. The row is kept open when the counter, including the current request, is at or above `adapt_thresh`; otherwise the bank closes as in R6.
- R8: `req_ready` is high only while idle. It is low from the cycle after an accept until the sequencer is idle again. Each accepted request yields exactly one `done_valid` pulse, and the first command appears in the cycle after the accept.
- R9: `cmd` is one-hot: bit 0 NOP, bit 1 precharge, bit 2 activate, bit 3 read, bit 4 write. `cmd_addr` carries the row with an activate and the column with a read or write; it is zero otherwise.
- R10: After reset the bank is closed, `req_ready` is 1, `cmd` is NOP and `done_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_row | input | ROW_W | Requested row |
| req_col | input | COL_W | Requested column |
| req_write | input | 1 | 1 = write, 0 = read |
| policy_sel | input | 2 | 0 open-page, 1 close-page, 2/3 adaptive |
| adapt_thresh | input | CNT_W | Adaptive threshold |
| t_rp | input | TW | Precharge-to-activate cycles |
| t_rcd | input | TW | Activate-to-column cycles |
| t_cl | input | TW | Column-to-completion cycles |
| cmd | output | 5 | One-hot command |
| cmd_addr | output | max(ROW_W,COL_W) | Row or column for the current command |
| done_valid | output | 1 | Single-cycle completion pulse |
| done_kind | output | 2 | 0 hit, 1 closed row, 2 conflict |

## Verification
Every result is due a known number of cycles after the accept edge:
- the first command appears one cycle after the accept;
- completion comes 1 + tCL cycles after accept for a hit, 1 + tRCD + tCL for a closed row, and 1 + tRP + tRCD + tCL for a conflict;
- `req_ready` returns in the cycle after completion, or tRP cycles after the auto-precharge when the bank closes.

The bench drives inputs and samples outputs on falling edges. It counts the cycles from the accept up to `done_valid` and compares that count with the formula for the expected kind. It tallies the precharge, activate and column commands seen in that window. It then counts the cycles until `req_ready` rises again, which shows whether the policy closed the bank.

// File: rtl/pgseq_pkg.sv
package pgseq_pkg;
  typedef enum logic [1:0] {
    KIND_HIT      = 2'd0,
    KIND_CLOSED   = 2'd1,
    KIND_CONFLICT = 2'd2
  } acc_kind_e;

  typedef enum logic [1:0] {
    POL_OPEN   = 2'd0,
    POL_CLOSE  = 2'd1,
    POL_ADAPT  = 2'd2,
    POL_ADAPT2 = 2'd3
  } policy_e;

  localparam int CMD_W   = 5;
  localparam int CMD_NOP = 0;
  localparam int CMD_PRE = 1;
  localparam int CMD_ACT = 2;
  localparam int CMD_RD  = 3;
  localparam int CMD_WR  = 4;

  typedef enum logic [3:0] {
    ST_IDLE, ST_PRE, ST_WAIT_RP, ST_ACT, ST_WAIT_RCD,
    ST_COL, ST_WAIT_CL, ST_DONE, ST_CLOSE, ST_WAIT_CLOSE
  } seq_state_e;
endpackage

// File: rtl/pgseq_row_tracker.sv
module pgseq_row_tracker
  import pgseq_pkg::*;
#(
  parameter int ROW_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_fire,
  input  logic [ROW_W-1:0] act_row,
  input  logic             pre_fire,
  input  logic [ROW_W-1:0] query_row,
  output logic             row_open,
  output acc_kind_e        query_kind
);
  logic [ROW_W-1:0] open_row_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_open   <= 1'b0;
      open_row_q <= '0;
    end else if (pre_fire) begin
      row_open <= 1'b0;
    end else if (act_fire) begin
      row_open   <= 1'b1;
      open_row_q <= act_row;
    end
  end

  always_comb begin
    if (!row_open)                  query_kind = KIND_CLOSED;
    else if (open_row_q == query_row) query_kind = KIND_HIT;
    else                            query_kind = KIND_CONFLICT;
  end
endmodule

// File: rtl/pgseq_adapt.sv
module pgseq_adapt
  import pgseq_pkg::*;
#(
  parameter int CNT_W    = 4,
  parameter int CNT_INIT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd,
  input  acc_kind_e        upd_kind,
  input  logic [CNT_W-1:0] thresh,
  input  logic [1:0]       policy,
  output logic             keep_open
);
  localparam logic [CNT_W-1:0] CNT_MAX   = '1;
  localparam logic [CNT_W-1:0] CNT_RESET = CNT_W'(CNT_INIT);

  logic [CNT_W-1:0] score_q;
  policy_e          pol;

  assign pol = policy_e'(policy);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      score_q <= CNT_RESET;
    end else if (upd) begin
      if (upd_kind == KIND_HIT && score_q != CNT_MAX)
        score_q <= score_q + CNT_W'(1);
      else if (upd_kind == KIND_CONFLICT && score_q != '0)
        score_q <= score_q - CNT_W'(1);
    end
  end

  always_comb begin
    case (pol)
      POL_OPEN:  keep_open = 1'b1;
      POL_CLOSE: keep_open = 1'b0;
      default:   keep_open = (score_q >= thresh);
    endcase
  end
endmodule

// File: rtl/pgseq_ctrl.sv
module pgseq_ctrl
  import pgseq_pkg::*;
#(
  parameter int ROW_W = 14,
  parameter int COL_W = 10,
  parameter int TW    = 4,
  parameter int AW    = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [ROW_W-1:0] req_row,
  input  logic [COL_W-1:0] req_col,
  input  logic             req_write,
  input  acc_kind_e        query_kind,
  input  logic             keep_open,
  input  logic [TW-1:0]    t_rp,
  input  logic [TW-1:0]    t_rcd,
  input  logic [TW-1:0]    t_cl,
  output logic [CMD_W-1:0] cmd,
  output logic [AW-1:0]    cmd_addr,
  output logic             done_valid,
  output logic [1:0]       done_kind,
  output logic             act_fire,
  output logic [ROW_W-1:0] act_row,
  output logic             pre_fire,
  output logic             acc_fire
);
  localparam int NT = 3;
  localparam int IX_RP  = 0;
  localparam int IX_RCD = 1;
  localparam int IX_CL  = 2;
  localparam logic [TW-1:0] ONE = TW'(1);

  logic [TW-1:0] t_raw [NT];
  logic [TW-1:0] t_eff [NT];

  assign t_raw[IX_RP]  = t_rp;
  assign t_raw[IX_RCD] = t_rcd;
  assign t_raw[IX_CL]  = t_cl;

  for (genvar g = 0; g < NT; g++) begin : g_clamp
    assign t_eff[g] = (t_raw[g] == '0) ? ONE : t_raw[g];
  end

  seq_state_e       state_q;
  logic [TW-1:0]    wait_q;
  logic [ROW_W-1:0] row_q;
  logic [COL_W-1:0] col_q;
  logic             wr_q;
  acc_kind_e        kind_q;

  assign req_ready = (state_q == ST_IDLE);
  assign acc_fire  = req_ready && req_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      wait_q  <= '0;
      row_q   <= '0;
      col_q   <= '0;
      wr_q    <= 1'b0;
      kind_q  <= KIND_HIT;
    end else begin
      case (state_q)
        ST_IDLE: if (req_valid) begin
          row_q  <= req_row;
          col_q  <= req_col;
          wr_q   <= req_write;
          kind_q <= query_kind;
          case (query_kind)
            KIND_HIT:    state_q <= ST_COL;
            KIND_CLOSED: state_q <= ST_ACT;
            default:     state_q <= ST_PRE;
          endcase
        end
        ST_PRE: begin
          wait_q  <= t_eff[IX_RP] - ONE;
          state_q <= (t_eff[IX_RP] == ONE) ? ST_ACT : ST_WAIT_RP;
        end
        ST_WAIT_RP: begin
          wait_q <= wait_q - ONE;
          if (wait_q == ONE) state_q <= ST_ACT;
        end
        ST_ACT: begin
          wait_q  <= t_eff[IX_RCD] - ONE;
          state_q <= (t_eff[IX_RCD] == ONE) ? ST_COL : ST_WAIT_RCD;
        end
        ST_WAIT_RCD: begin
          wait_q <= wait_q - ONE;
          if (wait_q == ONE) state_q <= ST_COL;
        end
        ST_COL: begin
          wait_q  <= t_eff[IX_CL] - ONE;
          state_q <= (t_eff[IX_CL] == ONE) ? ST_DONE : ST_WAIT_CL;
        end
        ST_WAIT_CL: begin
          wait_q <= wait_q - ONE;
          if (wait_q == ONE) state_q <= ST_DONE;
        end
        ST_DONE: state_q <= keep_open ? ST_IDLE : ST_CLOSE;
        ST_CLOSE: begin
          wait_q  <= t_eff[IX_RP] - ONE;
          state_q <= (t_eff[IX_RP] == ONE) ? ST_IDLE : ST_WAIT_CLOSE;
        end
        ST_WAIT_CLOSE: begin
          wait_q <= wait_q - ONE;
          if (wait_q == ONE) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    cmd      = '0;
    cmd_addr = '0;
    case (state_q)
      ST_PRE, ST_CLOSE: cmd[CMD_PRE] = 1'b1;
      ST_ACT: begin
        cmd[CMD_ACT] = 1'b1;
        cmd_addr     = AW'(row_q);
      end
      ST_COL: begin
        if (wr_q) cmd[CMD_WR] = 1'b1;
        else      cmd[CMD_RD] = 1'b1;
        cmd_addr = AW'(col_q);
      end
      default: cmd[CMD_NOP] = 1'b1;
    endcase
  end

  assign done_valid = (state_q == ST_DONE);
  assign done_kind  = kind_q;
  assign act_fire   = (state_q == ST_ACT);
  assign act_row    = row_q;
  assign pre_fire   = (state_q == ST_PRE) || (state_q == ST_CLOSE);
endmodule

// File: rtl/dram_page_sequencer.sv
module dram_page_sequencer
  import pgseq_pkg::*;
#(
  parameter int ROW_W    = 14,
  parameter int COL_W    = 10,
  parameter int TW       = 4,
  parameter int CNT_W    = 4,
  parameter int CNT_INIT = 8,
  localparam int AW = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [ROW_W-1:0] req_row,
  input  logic [COL_W-1:0] req_col,
  input  logic             req_write,
  input  logic [1:0]       policy_sel,
  input  logic [CNT_W-1:0] adapt_thresh,
  input  logic [TW-1:0]    t_rp,
  input  logic [TW-1:0]    t_rcd,
  input  logic [TW-1:0]    t_cl,
  output logic [4:0]       cmd,
  output logic [AW-1:0]    cmd_addr,
  output logic             done_valid,
  output logic [1:0]       done_kind
);
  acc_kind_e        query_kind;
  logic             keep_open;
  logic             act_fire;
  logic             pre_fire;
  logic             acc_fire;
  logic             row_open;
  logic [ROW_W-1:0] act_row;

  pgseq_row_tracker #(.ROW_W(ROW_W)) u_rows (
    .clk        (clk),
    .rst_n      (rst_n),
    .act_fire   (act_fire),
    .act_row    (act_row),
    .pre_fire   (pre_fire),
    .query_row  (req_row),
    .row_open   (row_open),
    .query_kind (query_kind)
  );

  pgseq_adapt #(.CNT_W(CNT_W), .CNT_INIT(CNT_INIT)) u_adapt (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd       (acc_fire),
    .upd_kind  (query_kind),
    .thresh    (adapt_thresh),
    .policy    (policy_sel),
    .keep_open (keep_open)
  );

  pgseq_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .TW(TW), .AW(AW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_row    (req_row),
    .req_col    (req_col),
    .req_write  (req_write),
    .query_kind (query_kind),
    .keep_open  (keep_open),
    .t_rp       (t_rp),
    .t_rcd      (t_rcd),
    .t_cl       (t_cl),
    .cmd        (cmd),
    .cmd_addr   (cmd_addr),
    .done_valid (done_valid),
    .done_kind  (done_kind),
    .act_fire   (act_fire),
    .act_row    (act_row),
    .pre_fire   (pre_fire),
    .acc_fire   (acc_fire)
  );
endmodule

// File: rtl/pgseq_checker.sv
module pgseq_checker #(
  parameter int TW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic [TW-1:0] t_rp,
  input logic [TW-1:0] t_rcd,
  input logic [TW-1:0] t_cl,
  input logic [4:0]    cmd,
  input logic          done_valid
);
  logic [7:0] since_pre, since_act, since_col;
  logic [7:0] rp_e, rcd_e, cl_e;

  assign rp_e  = (t_rp  == '0) ? 8'd1 : 8'(t_rp);
  assign rcd_e = (t_rcd == '0) ? 8'd1 : 8'(t_rcd);
  assign cl_e  = (t_cl  == '0) ? 8'd1 : 8'(t_cl);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_pre <= 8'hff;
      since_act <= 8'hff;
      since_col <= 8'hff;
    end else begin
      since_pre <= cmd[1] ? 8'd1 : ((since_pre == 8'hff) ? since_pre : since_pre + 8'd1);
      since_act <= cmd[2] ? 8'd1 : ((since_act == 8'hff) ? since_act : since_act + 8'd1);
      since_col <= (cmd[3] | cmd[4]) ? 8'd1 :
                   ((since_col == 8'hff) ? since_col : since_col + 8'd1);
    end
  end

  AST_CMD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot(cmd)); // R9
  AST_IDLE_NOP: assert property (@(posedge clk) disable iff (!rst_n) req_ready |-> cmd[0]); // R8
  AST_ACCEPT_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> (!req_ready && !cmd[0])); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done_valid |=> !done_valid); // R8
  AST_RP_SPACING: assert property (@(posedge clk) disable iff (!rst_n) cmd[2] |-> since_pre >= rp_e); // R4
  AST_RCD_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd[3] || cmd[4]) |-> since_act >= rcd_e); // R4
  AST_CL_EXACT: assert property (@(posedge clk) disable iff (!rst_n) done_valid |-> since_col == cl_e); // R4
endmodule

bind dram_page_sequencer pgseq_checker #(.TW(TW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .t_rp       (t_rp),
  .t_rcd      (t_rcd),
  .t_cl       (t_cl),
  .cmd        (cmd),
  .done_valid (done_valid)
);

// File: tb/tb_dram_page_sequencer.sv
module tb_dram_page_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 23;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [13:0] req_row = '0;
  logic [9:0]  req_col = '0;
  logic        req_write = 1'b0;
  logic [1:0]  policy_sel = 2'd0;
  logic [3:0]  adapt_thresh = 4'd8;
  logic [3:0]  t_rp = 4'd2, t_rcd = 4'd3, t_cl = 4'd4;
  logic [4:0]  cmd;
  logic [13:0] cmd_addr;
  logic        done_valid;
  logic [1:0]  done_kind;

  int checks = 0;
  int failures = 0;
  int model_cnt = 8;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_page_sequencer dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_row(req_row), .req_col(req_col), .req_write(req_write),
    .policy_sel(policy_sel), .adapt_thresh(adapt_thresh),
    .t_rp(t_rp), .t_rcd(t_rcd), .t_cl(t_cl),
    .cmd(cmd), .cmd_addr(cmd_addr), .done_valid(done_valid), .done_kind(done_kind)
  );

  // {policy, thresh, row, col, write, expected kind}
  localparam logic [24:0] VEC [NVEC] = '{
    {2'd0, 4'd8,  8'd5, 8'd1, 1'b0, 2'd1},
    {2'd0, 4'd8,  8'd5, 8'd2, 1'b1, 2'd0},
    {2'd0, 4'd8,  8'd9, 8'd3, 1'b0, 2'd2},
    {2'd0, 4'd8,  8'd9, 8'd4, 1'b0, 2'd0},
    {2'd1, 4'd8,  8'd9, 8'd5, 1'b0, 2'd0},
    {2'd1, 4'd8,  8'd9, 8'd6, 1'b1, 2'd1},
    {2'd1, 4'd8,  8'd3, 8'd7, 1'b0, 2'd1},
    {2'd2, 4'd8,  8'd3, 8'd0, 1'b0, 2'd1},
    {2'd2, 4'd8,  8'd3, 8'd1, 1'b1, 2'd0},
    {2'd2, 4'd12, 8'd7, 8'd2, 1'b0, 2'd2},
    {2'd2, 4'd12, 8'd7, 8'd3, 1'b0, 2'd1},
    {2'd3, 4'd10, 8'd7, 8'd4, 1'b1, 2'd1},
    {2'd3, 4'd10, 8'd7, 8'd5, 1'b0, 2'd0},
    {2'd2, 4'd10, 8'd2, 8'd6, 1'b0, 2'd2},
    {2'd2, 4'd10, 8'd2, 8'd7, 1'b1, 2'd0},
    {2'd2, 4'd0,  8'd2, 8'd8, 1'b0, 2'd0},
    {2'd2, 4'd0,  8'd2, 8'd9, 1'b0, 2'd0},
    {2'd2, 4'd0,  8'd2, 8'd10, 1'b1, 2'd0},
    {2'd2, 4'd0,  8'd2, 8'd11, 1'b0, 2'd0},
    {2'd2, 4'd0,  8'd2, 8'd12, 1'b0, 2'd0},
    {2'd2, 4'd0,  8'd2, 8'd13, 1'b0, 2'd0},
    {2'd2, 4'd15, 8'd2, 8'd14, 1'b0, 2'd0},
    {2'd2, 4'd15, 8'd2, 8'd15, 1'b1, 2'd0}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int eff(input logic [3:0] t);
    return (t == 0) ? 1 : int'(t);
  endfunction

  task automatic run_req(input logic [1:0] pol, input logic [3:0] thr, input int row,
                         input int col, input bit wr, input int kind);
    int lat = 1, npre = 0, nact = 0, ncol = 0, apre = 0, k = 0, exp_lat;
    bit addr_ok = 1, type_ok = 1, busy_ok = 1, closes;
    string ktag;
    policy_sel = pol; adapt_thresh = thr;
    req_row = 14'(row); req_col = 10'(col); req_write = wr; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (lat < 300) begin
      if (req_ready) busy_ok = 0;
      if (cmd[1]) npre++;
      if (cmd[2]) begin nact++; if (cmd_addr != 14'(row)) addr_ok = 0; end
      if (cmd[3] || cmd[4]) begin
        ncol++;
        if (cmd_addr != 14'(col)) addr_ok = 0;
        if (cmd[4] != wr) type_ok = 0;
      end
      if (done_valid) break;
      lat++;
      @(negedge clk);
    end
    ktag = (kind == 0) ? "R1" : (kind == 1) ? "R2" : "R3";
    exp_lat = 1 + eff(t_cl) + ((kind >= 1) ? eff(t_rcd) : 0) + ((kind == 2) ? eff(t_rp) : 0);
    chk(done_kind == 2'(kind), {ktag, " kind"}, int'(done_kind), kind);
    chk(lat == exp_lat, "R4 latency", lat, exp_lat);
    chk(npre == ((kind == 2) ? 1 : 0), {ktag, " precharge count"}, npre, (kind == 2) ? 1 : 0);
    chk(nact == ((kind >= 1) ? 1 : 0), {ktag, " activate count"}, nact, (kind >= 1) ? 1 : 0);
    chk(ncol == 1 && type_ok && addr_ok, "R9 command/address", ncol, 1);
    chk(busy_ok, "R8 ready low while busy", 0, 1);
    if (kind == 0 && model_cnt < 15) model_cnt++;
    if (kind == 2 && model_cnt > 0) model_cnt--;
    closes = (pol == 2'd1) || (pol >= 2'd2 && model_cnt < int'(thr));
    @(negedge clk);
    if (done_valid) chk(0, "R8 single done pulse", 1, 0);
    while (!req_ready && k < 100) begin
      if (cmd[1]) apre++;
      k++;
      @(negedge clk);
    end
    ktag = (pol == 2'd0) ? "R5" : (pol == 2'd1) ? "R6" : "R7";
    chk(k == (closes ? eff(t_rp) : 0), {ktag, " cycles to ready"}, k, closes ? eff(t_rp) : 0);
    chk(apre == (closes ? 1 : 0), {ktag, " auto precharge"}, apre, closes ? 1 : 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: reset state
    chk(req_ready == 1'b1, "R10 ready after reset", int'(req_ready), 1);
    chk(cmd == 5'b00001, "R10 NOP after reset", int'(cmd), 1);
    chk(done_valid == 1'b0, "R10 no done after reset", int'(done_valid), 0);

    for (int i = 0; i < NVEC; i++) begin
      run_req(VEC[i][24:23], VEC[i][22:19], int'(VEC[i][18:11]), int'(VEC[i][10:3]),
              VEC[i][2], int'(VEC[i][1:0]));
    end

    // R4: zero timing values act as one; conflict from open row 2
    t_rp = 4'd0; t_rcd = 4'd0; t_cl = 4'd0;
    run_req(2'd0, 4'd0, 4, 20, 1'b0, 2);
    // R1 with clamped timings, then long timings closed access
    run_req(2'd0, 4'd0, 4, 21, 1'b1, 0);
    t_rp = 4'd7; t_rcd = 4'd5; t_cl = 4'd6;
    run_req(2'd1, 4'd0, 11, 22, 1'b0, 2);
    run_req(2'd1, 4'd0, 11, 23, 1'b1, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule